// File: doc/BRIEF.md
# Interleaved Two-Stage PWM Generator

This block produces the four gate signals of a cascaded step-up/step-down power stage: one gate pair for the boost half and one for the buck half. It receives a single control word. It saturates the word, splits it into a boost duty and a buck duty, and chooses the operating mode. It then emits two-phase PWM for the active stage while holding the inactive stage at a fixed level.

The period is a free-running count of `PERIOD` clocks, which gives 50 kHz at 50 MHz with the default of 1000. The control word is unsigned fixed point. The value `PERIOD` stands for a duty of 1.0, so the default range 0..2000 covers a control value of 0.0 to 2.0. The word is captured only at the first cycle of a period, so every pulse is complete. The second gate of each pair is the first gate delayed by half a period.

Top module: `twostage_pwm`

## Requirements
- R1: The control word is clipped to 2*PERIOD (2000). A clipped value c of at most PERIOD selects buck mode with buck duty c counts and boost duty 0. A value above PERIOD selects boost mode with boost duty c-PERIOD counts and buck duty fully on.
- R2: In boost mode, `buck_a` and `buck_b` stay high every cycle. Over each period, `boost_a` is high on count positions 0..d-1, where d is the boost duty.
- R3: In buck mode, `boost_a` and `boost_b` stay low every cycle. Over each period, `buck_a` is high on count positions 0..d-1, where d is the buck duty.
- R4: Within a pair, gate b at count position i equals gate a at position (i+PERIOD/2) mod PERIOD, which is a lag of exactly half a period.
- R5: A period lasts PERIOD clocks. The first period starts on the first clock edge at which `en` is sampled high, and each later period starts directly after the previous one.
- R6: The control word is captured only on the last cycle of a period, or on the enabling edge. A change in mid-period has no effect until the next period.
- R7: A duty of 0 keeps the switching gates low for the whole period, and a duty of PERIOD keeps them high for the whole period. Control word 1000 gives buck mode with the buck gates always on.
- R8: While `rst_n` is low, and from the first edge at which `en` is sampled low, all four gates are low and `boost_mode` is 0.
- R9: `boost_mode` is 1 during a period running in boost mode and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 50 MHz nominal |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Run enable; low forces all gates off |
| ctrl | input | CTRL_W (11) | Unified control word, PERIOD units = 1.0 |
| boost_a | output | 1 | Boost stage gate, leading phase |
| boost_b | output | 1 | Boost stage gate, lagging phase |
| buck_a | output | 1 | Buck stage gate, leading phase |
| buck_b | output | 1 | Buck stage gate, lagging phase |
| boost_mode | output | 1 | 1 while running in boost mode |

## Verification
The assertions assume that `ctrl` may take any value, including values above the saturation limit, and that `en` may drop at any cycle. They do not assume that `ctrl` is held steady across a period, because the design captures it itself. The stimulus changes `ctrl` and `en` only on falling clock edges, so no input moves at the sampling edge. It also covers the values just past each boundary (0, 1000, 1001, 2000 and 2047), so the clipping and mode split are exercised at their edges.

// File: rtl/twostage_pwm.sv
module twostage_pwm #(
  parameter int PERIOD = 1000,
  parameter int CTRL_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [CTRL_W-1:0] ctrl,
  output logic              boost_a,
  output logic              boost_b,
  output logic              buck_a,
  output logic              buck_b,
  output logic              boost_mode
);
  localparam int HALF = PERIOD / 2;
  localparam int TOP  = 2 * PERIOD;
  localparam int CW   = $clog2(PERIOD);
  localparam int DW   = $clog2(PERIOD + 1);

  logic [CW-1:0]     cnt, cnt_lag;
  logic [DW-1:0]     duty;
  logic              act, mode_q, ph_a, ph_b;
  logic [CTRL_W-1:0] csat, dsel;
  logic              up_sel;

  assign csat   = (ctrl > CTRL_W'(TOP)) ? CTRL_W'(TOP) : ctrl;
  assign up_sel = csat > CTRL_W'(PERIOD);
  assign dsel   = up_sel ? csat - CTRL_W'(PERIOD) : csat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act    <= 1'b0;
      cnt    <= '0;
      duty   <= '0;
      mode_q <= 1'b0;
    end else if (!en) begin
      act <= 1'b0;
      cnt <= '0;
    end else begin
      act <= 1'b1;
      if (!act || cnt == CW'(PERIOD - 1)) begin
        cnt    <= '0;
        duty   <= DW'(dsel);
        mode_q <= up_sel;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign cnt_lag = (cnt >= CW'(HALF)) ? cnt - CW'(HALF) : cnt + CW'(HALF);
  assign ph_a    = DW'(cnt) < duty;
  assign ph_b    = DW'(cnt_lag) < duty;

  assign boost_a    = act & mode_q & ph_a;
  assign boost_b    = act & mode_q & ph_b;
  assign buck_a     = act & (mode_q | ph_a);
  assign buck_b     = act & (mode_q | ph_b);
  assign boost_mode = act & mode_q;

  AST_IDLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !(boost_a | boost_b | buck_a | buck_b | boost_mode)); // R8

  AST_BOOST_BUCK_ON: assert property (@(posedge clk) disable iff (!rst_n)
    boost_mode |-> (buck_a && buck_b)); // R2

  AST_BUCK_BOOST_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !boost_mode |-> !(boost_a || boost_b)); // R3

  AST_LATCH_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    (act && $past(act) && cnt != '0) |-> ($stable(duty) && $stable(mode_q))); // R6

  AST_PERIOD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (act && $past(act) && $past(cnt) == CW'(PERIOD - 1)) |-> cnt == '0); // R5

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(PERIOD)); // R5

  AST_DUTY_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    duty <= DW'(PERIOD)); // R1
endmodule

// File: tb/sim_twostage_pwm.sv
module sim_twostage_pwm;
  localparam int P = 1000;
  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic [10:0] ctrl = '0;
  logic boost_a, boost_b, buck_a, buck_b, boost_mode;
  int nchk = 0, nerr = 0;
  bit done = 0;

  twostage_pwm u0 (.clk(clk), .rst_n(rst_n), .en(en), .ctrl(ctrl),
    .boost_a(boost_a), .boost_b(boost_b), .buck_a(buck_a), .buck_b(buck_b),
    .boost_mode(boost_mode));

  always #10 clk = ~clk;

  logic wua [0:P-1];
  logic wub [0:P-1];
  logic wda [0:P-1];
  logic wdb [0:P-1];
  logic wmd [0:P-1];

  task automatic chk(input bit ok, input string req, input int got, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic start(input logic [10:0] c);
    @(negedge clk); en = 1'b0;
    @(negedge clk); ctrl = c; en = 1'b1;
    @(negedge clk);
  endtask

  task automatic grab(input int chg_at, input logic [10:0] newc);
    for (int i = 0; i < P; i++) begin
      if (i == chg_at) ctrl = newc;
      wua[i] = boost_a; wub[i] = boost_b;
      wda[i] = buck_a;  wdb[i] = buck_b;
      wmd[i] = boost_mode;
      @(negedge clk);
    end
  endtask

  task automatic check_period(input string req, input bit bm, input int d);
    int eua = 0, eub = 0, eda = 0, edb = 0, emd = 0;
    for (int i = 0; i < P; i++) begin
      logic xa, xb;
      xa = i < d;
      xb = ((i + P / 2) % P) < d;
      if (wua[i] !== (bm ? xa : 1'b0)) eua++;
      if (wub[i] !== (bm ? xb : 1'b0)) eub++;
      if (wda[i] !== (bm ? 1'b1 : xa)) eda++;
      if (wdb[i] !== (bm ? 1'b1 : xb)) edb++;
      if (wmd[i] !== bm) emd++;
    end
    chk(eua == 0, {req, " boost_a cycles wrong"}, eua, 0);
    chk(eub == 0, {req, " boost_b cycles wrong (R4 lag)"}, eub, 0);
    chk(eda == 0, {req, " buck_a cycles wrong"}, eda, 0);
    chk(edb == 0, {req, " buck_b cycles wrong (R4 lag)"}, edb, 0);
    chk(emd == 0, {req, " boost_mode cycles wrong (R9)"}, emd, 0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk({boost_a, boost_b, buck_a, buck_b, boost_mode} == 5'b0, "R8 reset outputs",
        int'({boost_a, boost_b, buck_a, buck_b, boost_mode}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({boost_a, boost_b, buck_a, buck_b, boost_mode} == 5'b0, "R8 idle after reset",
        int'({boost_a, boost_b, buck_a, buck_b, boost_mode}), 0);
  endtask

  task automatic t_mode(input logic [10:0] c, input string req, input bit bm, input int d);
    start(c);
    grab(-1, c);
    check_period(req, bm, d);
    grab(-1, c);
    check_period({req, " R5 second period"}, bm, d);
  endtask

  task automatic t_latch();
    start(11'd300);
    grab(400, 11'd1700);
    check_period("R6 mid-period change ignored", 1'b0, 300);
    grab(-1, 11'd1700);
    check_period("R6 new word at next period", 1'b1, 700);
  endtask

  task automatic t_disable();
    start(11'd1600);
    repeat (123) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk({boost_a, boost_b, buck_a, buck_b, boost_mode} == 5'b0, "R8 en low forces off",
        int'({boost_a, boost_b, buck_a, buck_b, boost_mode}), 0);
    ctrl = 11'd1900;
    repeat (20) @(negedge clk);
    chk({boost_a, boost_b, buck_a, buck_b, boost_mode} == 5'b0, "R8 stays off while disabled",
        int'({boost_a, boost_b, buck_a, buck_b, boost_mode}), 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    nchk++; nerr++;
    $display("FAIL watchdog: got 1 expected 0");
    finish_run();
  end

  initial begin
    t_reset();
    t_mode(11'd300,  "R1 R3 buck 300", 1'b0, 300);
    t_mode(11'd700,  "R3 R4 buck 700", 1'b0, 700);
    t_mode(11'd1250, "R1 R2 boost 250", 1'b1, 250);
    t_mode(11'd1001, "R7 boost duty 1", 1'b1, 1);
    t_mode(11'd1000, "R7 buck full on", 1'b0, 1000);
    t_mode(11'd0,    "R7 buck zero", 1'b0, 0);
    t_mode(11'd2000, "R7 boost full on", 1'b1, 1000);
    t_mode(11'd2047, "R1 saturation", 1'b1, 1000);
    t_latch();
    t_disable();
    finish_run();
  end
endmodule